// File: doc/BRIEF.md
# Branch-Resolving Fetch Sequencer

This block is the front end of an in-order pipeline. It decides what the fetch slot holds in the cycles around a conditional branch. It supplies the fetch address, takes a branch flag back with each fetched word, and carries tags for the next two stages: decode, and the resolve stage where a branch learns its direction and target. A branch fetched in cycle t reaches the resolve stage in cycle t+2. A redirect issued there is fetched in cycle t+3.

A two-bit policy input picks how the two-cycle gap after a branch is handled:

- **Stall.** Fetch stops for two cycles after every branch.
- **Predict-not-taken.** Fetch carries on down the sequential path. The two younger instructions are tagged as killed when the branch turns out taken.
- **Delayed.** Fetch carries on and the two younger instructions always run.

Policy code 0 selects stall and code 3 behaves the same. Code 1 selects predict-not-taken and code 2 selects delayed. The policy may change only while reset is held.

A counter of wasted slots lets the branch cost per instruction be worked out at run time. It counts empty fetch slots plus killed instructions.

The stall gap is run by a three-state machine:

- `ST_RUN` fetches every cycle. It moves to `ST_BUB1` when a branch is fetched under the stall policy.
- `ST_BUB1` leaves the fetch slot empty and always moves on to `ST_BUB2`.
- `ST_BUB2` leaves the fetch slot empty and always returns to `ST_RUN`.

Top module: `fetch_seq`

## Requirements
- R1: A synchronous active-high reset sets the fetch address to the `RESET_PC` parameter, clears the decode and resolve valid bits, clears the wasted-slot counter and enters `ST_RUN`. In the first cycle after reset the fetch slot is valid.
- R2: The address advances by 4 after each cycle with a valid fetch and holds across an empty fetch slot. Each fetched instruction appears one cycle later as valid in decode and two cycles later as valid in resolve, with its own address on `br_pc_o`.
- R3: Under policy 0 or 3, a branch fetched in cycle t leaves the fetch slot empty in cycles t+1 and t+2, whatever the outcome. Fetch resumes in cycle t+3.
- R4: A redirect happens when the resolve stage holds a valid, not-killed branch and both `res_valid_i` and `res_taken_i` are high. The cycle after a redirect fetches `res_target_i`, under every policy. When `res_valid_i` is low the branch falls through.
- R5: Under policy 1 the fetch slot is never empty. A branch that falls through costs no cycles.
- R6: Under policy 1 a redirect sets the kill tag on both younger instructions, as they move into decode and into resolve.
- R7: Under policy 2 the fetch slot is never empty and no kill tag is ever set.
- R8: A branch that reaches resolve with its kill tag set never redirects. The next fetch is the sequential address.
- R9: The wasted-slot counter adds 1 for each empty fetch slot and 1 for each instruction killed. This gives 2 per branch under stall, 2 per redirect under policy 1, and 0 under policy 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Branch policy: 0 stall, 1 predict-not-taken, 2 delayed, 3 stall |
| fetch_pc_o | output | PC_W | Address of the fetch slot |
| fetch_valid_o | output | 1 | Fetch slot holds a real fetch (low for a bubble) |
| fetch_is_br_i | input | 1 | Word fetched from `fetch_pc_o` is a conditional branch |
| res_valid_i | input | 1 | Resolve result is available for the branch in the resolve stage |
| res_taken_i | input | 1 | Branch in the resolve stage is taken |
| res_target_i | input | PC_W | Target of the branch in the resolve stage |
| de_valid_o | output | 1 | Decode stage holds an instruction |
| de_kill_o | output | 1 | Decode stage instruction is killed |
| br_valid_o | output | 1 | Resolve stage holds an instruction |
| br_kill_o | output | 1 | Resolve stage instruction is killed |
| br_pc_o | output | PC_W | Address of the instruction in the resolve stage |
| waste_cnt_o | output | CNT_W | Wasted slots since reset |

## Verification
Each policy is run against the same set of branch layouts:

- **Sparse random branches.** These check the plain sequential stream and isolated redirects.
- **Dense, mostly taken branches.** Branches then land inside the shadow of older ones. This separates the policies: under predict-not-taken such branches are killed and must not redirect, while under delayed they resolve and redirect one after another.
- **Back-to-back fall-through branches.** These show that only the stall policy pays for a branch that falls through.
- **A taken branch whose resolve valid is low.** This shows that the qualifier gates the redirect.

The wasted-slot counter is compared each cycle against the branch-cost formula for the active policy.

// File: rtl/fetch_seq_pkg.sv
`timescale 1ns/1ps
package fetch_seq_pkg;

    typedef enum logic [1:0] {
        POL_STALL = 2'd0,
        POL_PNT   = 2'd1,
        POL_DELAY = 2'd2,
        POL_RSVD  = 2'd3
    } policy_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_BUB1 = 2'd1,
        ST_BUB2 = 2'd2
    } fstate_e;

    typedef struct packed {
        logic valid;
        logic kill;
        logic branch;
    } stag_t;

endpackage

// File: rtl/fseq_ctrl.sv
`timescale 1ns/1ps
module fseq_ctrl
    import fetch_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  policy_e policy,
    input  logic    fetch_is_br,
    output logic    fetch_en,
    output logic    bubble
);

    fstate_e st_q;
    fstate_e st_d;
    logic    stall_pol;

    assign stall_pol = (policy == POL_STALL) || (policy == POL_RSVD);

    // next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:  if (fetch_is_br && stall_pol) st_d = ST_BUB1;
            ST_BUB1: st_d = ST_BUB2;
            ST_BUB2: st_d = ST_RUN;
            default: st_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_RUN;
        else     st_q <= st_d;
    end

    // outputs
    always_comb begin
        fetch_en = 1'b0;
        bubble   = 1'b0;
        unique case (st_q)
            ST_RUN:           fetch_en = 1'b1;
            ST_BUB1, ST_BUB2: bubble   = 1'b1;
            default:          bubble   = 1'b0;
        endcase
    end

endmodule

// File: rtl/fseq_stages.sv
`timescale 1ns/1ps
module fseq_stages
    import fetch_seq_pkg::*;
#(
    parameter int unsigned PC_W = 32,
    parameter int unsigned NSTG = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fetch_en,
    input  logic            fetch_is_br,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            squash,
    output logic [NSTG-1:0] valid_o,
    output logic [NSTG-1:0] kill_o,
    output logic            last_branch_o,
    output logic [PC_W-1:0] last_pc_o
);

    stag_t           tag_q [NSTG];
    logic [PC_W-1:0] pc_q  [NSTG];

    for (genvar i = 0; i < NSTG; i++) begin : g_stg
        stag_t           in_tag;
        logic [PC_W-1:0] in_pc;

        if (i == 0) begin : g_head
            always_comb begin
                in_tag.valid  = fetch_en;
                in_tag.kill   = fetch_en & squash;
                in_tag.branch = fetch_en & fetch_is_br;
                in_pc         = fetch_pc;
            end
        end else begin : g_body
            always_comb begin
                in_tag.valid  = tag_q[i-1].valid;
                in_tag.kill   = tag_q[i-1].kill | (tag_q[i-1].valid & squash);
                in_tag.branch = tag_q[i-1].branch;
                in_pc         = pc_q[i-1];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q[i] <= '0;
                pc_q[i]  <= '0;
            end else begin
                tag_q[i] <= in_tag;
                pc_q[i]  <= in_pc;
            end
        end
    end

    always_comb begin
        for (int k = 0; k < NSTG; k++) begin
            valid_o[k] = tag_q[k].valid;
            kill_o[k]  = tag_q[k].kill;
        end
        last_branch_o = tag_q[NSTG-1].branch;
        last_pc_o     = pc_q[NSTG-1];
    end

endmodule

// File: rtl/fseq_waste.sv
`timescale 1ns/1ps
module fseq_waste #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bubble,
    input  logic             squash,
    input  logic             fetch_en,
    input  logic             de_live,
    output logic [CNT_W-1:0] cnt_o
);

    logic [1:0]       inc;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        inc = {1'b0, bubble};
        if (squash) inc = inc + {1'b0, fetch_en} + {1'b0, de_live};
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + CNT_W'(inc);
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/fetch_seq.sv
`timescale 1ns/1ps
module fetch_seq
    import fetch_seq_pkg::*;
#(
    parameter int unsigned     PC_W     = 32,
    parameter logic [PC_W-1:0] RESET_PC = '0,
    parameter int unsigned     CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_i,
    output logic [PC_W-1:0]  fetch_pc_o,
    output logic             fetch_valid_o,
    input  logic             fetch_is_br_i,
    input  logic             res_valid_i,
    input  logic             res_taken_i,
    input  logic [PC_W-1:0]  res_target_i,
    output logic             de_valid_o,
    output logic             de_kill_o,
    output logic             br_valid_o,
    output logic             br_kill_o,
    output logic [PC_W-1:0]  br_pc_o,
    output logic [CNT_W-1:0] waste_cnt_o
);

    localparam int unsigned     RES_STAGE = 3;
    localparam int unsigned     NSTG      = RES_STAGE - 1;
    localparam logic [PC_W-1:0] PC_STEP   = PC_W'(4);

    policy_e         policy;
    logic            fetch_en;
    logic            bubble;
    logic [NSTG-1:0] stg_valid;
    logic [NSTG-1:0] stg_kill;
    logic            br_branch;
    logic            br_live;
    logic            redirect;
    logic            squash;
    logic            de_live;
    logic [PC_W-1:0] pc_q;

    assign policy   = policy_e'(mode_i);
    assign br_live  = stg_valid[NSTG-1] & ~stg_kill[NSTG-1] & br_branch;
    assign redirect = br_live & res_valid_i & res_taken_i;
    assign squash   = redirect & (policy == POL_PNT);
    assign de_live  = stg_valid[0] & ~stg_kill[0];

    fseq_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .policy      (policy),
        .fetch_is_br (fetch_is_br_i),
        .fetch_en    (fetch_en),
        .bubble      (bubble)
    );

    fseq_stages #(.PC_W(PC_W), .NSTG(NSTG)) u_stages (
        .clk           (clk),
        .rst           (rst),
        .fetch_en      (fetch_en),
        .fetch_is_br   (fetch_is_br_i),
        .fetch_pc      (pc_q),
        .squash        (squash),
        .valid_o       (stg_valid),
        .kill_o        (stg_kill),
        .last_branch_o (br_branch),
        .last_pc_o     (br_pc_o)
    );

    fseq_waste #(.CNT_W(CNT_W)) u_waste (
        .clk      (clk),
        .rst      (rst),
        .bubble   (bubble),
        .squash   (squash),
        .fetch_en (fetch_en),
        .de_live  (de_live),
        .cnt_o    (waste_cnt_o)
    );

    always_ff @(posedge clk) begin
        if (rst)           pc_q <= RESET_PC;
        else if (redirect) pc_q <= res_target_i;
        else if (fetch_en) pc_q <= pc_q + PC_STEP;
    end

    assign fetch_pc_o    = pc_q;
    assign fetch_valid_o = fetch_en;
    assign de_valid_o    = stg_valid[0];
    assign de_kill_o     = stg_kill[0];
    assign br_valid_o    = stg_valid[NSTG-1];
    assign br_kill_o     = stg_kill[NSTG-1];

endmodule

// File: rtl/fetch_seq_chk.sv
`timescale 1ns/1ps
module fetch_seq_chk #(
    parameter int unsigned     PC_W     = 32,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input logic            clk,
    input logic            rst,
    input logic [1:0]      mode_i,
    input logic            fetch_valid_o,
    input logic            fetch_is_br_i,
    input logic [PC_W-1:0] fetch_pc_o,
    input logic            de_valid_o,
    input logic            de_kill_o,
    input logic            br_valid_o,
    input logic            br_kill_o,
    input logic            res_valid_i,
    input logic            res_taken_i,
    input logic [PC_W-1:0] res_target_i,
    input logic            br_live
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fetch_pc_o == RESET_PC && fetch_valid_o && !de_valid_o && !br_valid_o));

    // R3
    stall_gap_a_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid_o && fetch_is_br_i && (mode_i == 2'd0 || mode_i == 2'd3)) |=> !fetch_valid_o);

    // R3
    stall_gap_b_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid_o && fetch_is_br_i && (mode_i == 2'd0 || mode_i == 2'd3)) |=> ##1 !fetch_valid_o);

    // R3
    stall_resume_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid_o && fetch_is_br_i && (mode_i == 2'd0 || mode_i == 2'd3)) |=> ##2 fetch_valid_o);

    // R4
    redirect_target_chk: assert property (@(posedge clk) disable iff (rst)
        (br_live && res_valid_i && res_taken_i) |=> (fetch_valid_o && fetch_pc_o == $past(res_target_i)));

    // R5
    no_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd1 || mode_i == 2'd2) |-> fetch_valid_o);

    // R6
    shadow_kill_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd1 && br_live && res_valid_i && res_taken_i) |=> (de_kill_o && br_kill_o));

    // R7
    delay_no_kill_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd2) |-> (!de_kill_o && !br_kill_o));

    // R8
    killed_no_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd1 && br_valid_o && br_kill_o) |=> fetch_pc_o == $past(fetch_pc_o) + PC_W'(4));

endmodule

bind fetch_seq fetch_seq_chk #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_fetch_seq_chk (
    .clk           (clk),
    .rst           (rst),
    .mode_i        (mode_i),
    .fetch_valid_o (fetch_valid_o),
    .fetch_is_br_i (fetch_is_br_i),
    .fetch_pc_o    (fetch_pc_o),
    .de_valid_o    (de_valid_o),
    .de_kill_o     (de_kill_o),
    .br_valid_o    (br_valid_o),
    .br_kill_o     (br_kill_o),
    .res_valid_i   (res_valid_i),
    .res_taken_i   (res_taken_i),
    .res_target_i  (res_target_i),
    .br_live       (br_live)
);

// File: tb/test_fetch_seq.sv
`timescale 1ns/1ps
module test_fetch_seq;

    localparam int unsigned PC_W   = 32;
    localparam logic [31:0] RST_PC = 32'h0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'd0;
    logic [31:0] fetch_pc;
    logic        fetch_valid;
    logic        fetch_is_br;
    logic        res_valid;
    logic        res_taken;
    logic [31:0] res_target;
    logic        de_valid, de_kill, br_valid, br_kill;
    logic [31:0] br_pc;
    logic [15:0] waste;

    always #2 clk = ~clk;

    // program image: branch flag, outcome, resolve-valid and target per word
    bit          isbr_t [64];
    bit          tk_t   [64];
    bit          rv_t   [64];
    logic [31:0] tgt_t  [64];

    assign fetch_is_br = isbr_t[fetch_pc[7:2]];
    assign res_valid   = rv_t[br_pc[7:2]];
    assign res_taken   = tk_t[br_pc[7:2]];
    assign res_target  = tgt_t[br_pc[7:2]];

    fetch_seq #(.PC_W(PC_W), .RESET_PC(RST_PC), .CNT_W(16)) i_fetch_seq (
        .clk           (clk),
        .rst           (rst),
        .mode_i        (mode),
        .fetch_pc_o    (fetch_pc),
        .fetch_valid_o (fetch_valid),
        .fetch_is_br_i (fetch_is_br),
        .res_valid_i   (res_valid),
        .res_taken_i   (res_taken),
        .res_target_i  (res_target),
        .de_valid_o    (de_valid),
        .de_kill_o     (de_kill),
        .br_valid_o    (br_valid),
        .br_kill_o     (br_kill),
        .br_pc_o       (br_pc),
        .waste_cnt_o   (waste)
    );

    int vectors = 0;
    int miscompares = 0;

    // bench model of the front end
    logic [31:0] m_pc;
    int          m_hold;
    bit          mv [2];
    bit          mk [2];
    bit          mb [2];
    logic [31:0] mp [2];
    int          n_br;
    int          n_red;
    string       pc_tag;

    function automatic bit is_stall(logic [1:0] md);
        return (md == 2'd0) || (md == 2'd3);
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s mode=%0d: actual %0h expected %0h", tag, what, mode, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pc   = RST_PC;
        m_hold = 0;
        for (int i = 0; i < 2; i++) begin
            mv[i] = 0; mk[i] = 0; mb[i] = 0; mp[i] = '0;
        end
        n_br   = 0;
        n_red  = 0;
        pc_tag = "R2";
    endtask

    task automatic compare_cycle();
        bit          fv;
        string       vtag;
        string       ktag;
        logic [31:0] exp_w;
        fv   = (m_hold == 0);
        vtag = is_stall(mode) ? "R3" : ((mode == 2'd1) ? "R5" : "R7");
        ktag = (mode == 2'd2) ? "R7" : "R6";
        chk(fetch_valid == fv, vtag, "fetch_valid", 32'(fetch_valid), 32'(fv));
        if (fv) chk(fetch_pc == m_pc, pc_tag, "fetch_pc", fetch_pc, m_pc);
        chk(de_valid == mv[0], "R2", "de_valid", 32'(de_valid), 32'(mv[0]));
        chk(br_valid == mv[1], "R2", "br_valid", 32'(br_valid), 32'(mv[1]));
        chk(de_kill == mk[0], ktag, "de_kill", 32'(de_kill), 32'(mk[0]));
        chk(br_kill == mk[1], ktag, "br_kill", 32'(br_kill), 32'(mk[1]));
        if (mv[1]) chk(br_pc == mp[1], "R2", "br_pc", br_pc, mp[1]);
        // R9: branch cost = 2 per branch (stall), 2 per redirect (not-taken prediction), 0 (delayed)
        if (is_stall(mode))     exp_w = 32'(2 * n_br - m_hold);
        else if (mode == 2'd1)  exp_w = 32'(2 * n_red);
        else                    exp_w = 32'd0;
        chk(32'(waste) == exp_w, "R9", "waste_cnt", 32'(waste), exp_w);
    endtask

    task automatic model_step();
        bit fv;
        bit live;
        bit red;
        bit sq;
        bit fbr;
        int bi;
        fv   = (m_hold == 0);
        live = mv[1] && !mk[1] && mb[1];
        bi   = int'(mp[1][7:2]);
        red  = live && rv_t[bi] && tk_t[bi];
        sq   = red && (mode == 2'd1);
        fbr  = fv && isbr_t[m_pc[7:2]];
        if (red)                              pc_tag = "R4";
        else if (mv[1] && mk[1] && mb[1])     pc_tag = "R8";
        else                                  pc_tag = "R2";
        if (sq) n_red++;
        if (fbr && is_stall(mode)) n_br++;
        mv[1] = mv[0]; mk[1] = mk[0] | (mv[0] & sq); mb[1] = mb[0]; mp[1] = mp[0];
        mv[0] = fv;    mk[0] = fv & sq;              mb[0] = fbr;   mp[0] = m_pc;
        if (fbr && is_stall(mode)) m_hold = 2;
        else if (m_hold > 0)       m_hold = m_hold - 1;
        if (red)     m_pc = tgt_t[bi];
        else if (fv) m_pc = m_pc + 32'd4;
    endtask

    task automatic run_phase(logic [1:0] md, int ncyc);
        mode = md;
        rst  = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        // R1: state right after reset
        chk(fetch_pc == RST_PC, "R1", "reset fetch_pc", fetch_pc, RST_PC);
        chk(fetch_valid == 1'b1, "R1", "reset fetch_valid", 32'(fetch_valid), 32'd1);
        chk(!de_valid && !br_valid, "R1", "reset stage valid", 32'({de_valid, br_valid}), 32'd0);
        chk(waste == 16'd0, "R1", "reset waste", 32'(waste), 32'd0);
        model_step();
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            compare_cycle();
            model_step();
        end
    endtask

    task automatic fill_clear();
        for (int i = 0; i < 64; i++) begin
            isbr_t[i] = 0; tk_t[i] = 0; rv_t[i] = 1; tgt_t[i] = '0;
        end
    endtask

    task automatic fill_rand(int brp, int tkp);
        for (int i = 0; i < 64; i++) begin
            isbr_t[i] = ($urandom % 100) < brp;
            tk_t[i]   = ($urandom % 100) < tkp;
            rv_t[i]   = ($urandom % 8) != 0;
            tgt_t[i]  = 32'(($urandom % 64) * 4);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        void'($urandom(32'd4711));
        fill_clear();
        // directed: taken branch followed by a taken branch in its shadow (R6, R7, R8)
        for (int m = 0; m < 3; m++) begin
            fill_clear();
            isbr_t[0] = 1; tk_t[0] = 1; tgt_t[0] = 32'h80;
            isbr_t[1] = 1; tk_t[1] = 1; tgt_t[1] = 32'h40;
            run_phase(2'(m), 30);
        end
        // directed: back-to-back fall-through branches (R3, R5)
        for (int m = 0; m < 3; m++) begin
            fill_clear();
            for (int i = 0; i < 4; i++) isbr_t[i] = 1;
            run_phase(2'(m), 24);
        end
        // directed: taken branch whose resolve valid is low falls through (R4)
        fill_clear();
        isbr_t[2] = 1; tk_t[2] = 1; rv_t[2] = 0; tgt_t[2] = 32'h20;
        isbr_t[5] = 1; tk_t[5] = 1; tgt_t[5] = 32'h0;
        run_phase(2'd1, 20);
        // random programs under every policy, including code 3 as stall (R3)
        for (int m = 0; m < 4; m++) begin
            fill_rand(25, 50);
            run_phase(2'(m), 3000);
            fill_rand(60, 80);
            run_phase(2'(m), 2000);
        end
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule